// File: doc/BRIEF.md
# Parallel RGB Panel Scan Timing Generator

This block drives the scan of a 1024x600 panel that takes 24-bit parallel RGB, and runs on one dot-clock domain. It keeps a column counter and a line counter. From them it decodes a data-enable strobe and two active-low sync pulses, and it asks an upstream pixel source for data one clock before every active pixel. The returned 24-bit word goes to the panel during the active region. Outside that region the pixel bus is held at zero.

The active area is fixed at build time. The total line length and the total frame height can be rewritten while the block runs, but only inside legal bounds that keep the blanking intervals legal. A write that is accepted waits in a pending register and takes effect at the next frame boundary. A panel-mode output tells the panel whether to use the data-enable strobe (high) or the sync pulses (low). It follows a request input that is sampled at frame boundaries, so it never changes in the middle of a frame.

Top module: `rgb_scan_gen`

## Requirements
- R1: While `rst` is high, `de` and `pix_req` are 0, `hsync_n` and `vsync_n` are 1, `pix_out` is 0, both counters read 0 and `panel_mode` reads 1. In the first cycle after `rst` falls, the counters stay at 0 and `de` stays low. From the next cycle on, the scan runs from column 0 of line 0.
- R2: The column counter advances by one each clock from 0 to line total minus 1, then returns to 0. The line counter advances when the column wraps and returns to 0 after frame total minus 1.
- R3: While the scan runs, `de` is 1 exactly when the column is below H_ACT (1024) and the line is below V_ACT (600).
- R4: `hsync_n` is 0 for columns H_ACT to H_ACT+HSYNC_W-1 (default width 20) on every line. `vsync_n` is 0 for every column of lines V_ACT to V_ACT+VSYNC_W-1 (default 3 lines). Both are 1 at all other times.
- R5: `pix_req` is 1 in a cycle exactly when `de` will be 1 in the following cycle. This covers a one-cycle upstream read latency.
- R6: `pix_out` equals `pix_in` when `de` is 1 and is 0 otherwise. The bit order passes through unchanged: blue in [23:16], green in [15:8] and red in [7:0].
- R7: A `cfg_we` pulse loads `cfg_htotal` into the pending line total only if the value is in the range H_TOT_MIN to H_TOT_MAX (1324 to 1364). Otherwise the previous pending value is kept. The pending value becomes active when the counters wrap from the last position of a frame.
- R8: A `cfg_we` pulse loads `cfg_vtotal` into the pending frame total only if the value is in the range V_TOT_MIN to V_TOT_MAX (625 to 645), independently of R7. The pending value becomes active at the same frame boundary.
- R9: `panel_mode` takes the value of `mode_req` only at the frame-boundary wrap. A value of 1 selects data-enable mode and 0 selects sync mode.
- R10: After reset the active and pending totals are H_TOT_DEF (1344) and V_TOT_DEF (635).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for both totals |
| cfg_htotal | input | HW | Requested line total in clocks |
| cfg_vtotal | input | VW | Requested frame total in lines |
| mode_req | input | 1 | Requested panel mode, 1 = data-enable mode |
| pix_in | input | 24 | Pixel word from the upstream source, one cycle after request |
| pix_req | output | 1 | Pixel request, one clock ahead of the active region |
| pix_out | output | 24 | Pixel word to the panel, zero outside the active region |
| de | output | 1 | Data-enable strobe |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| panel_mode | output | 1 | Panel mode select, 1 = data-enable, 0 = sync |
| h_cnt | output | HW | Current column |
| v_cnt | output | VW | Current line |

## Verification
The bench shrinks the geometry to a 16x6 active area. The line total is legal from 24 to 28 (default 26), the frame total from 9 to 11 (default 10), and the sync widths are 3 clocks and 2 lines. With a frame of only a few hundred clocks, a run covers dozens of frame wraps with pending writes, mode changes and resets in the middle of a frame. Random write values cover both sides of each bound, so values just outside the range are rejected and the end values are accepted, along with the shortest and longest frames.

// File: rtl/rgb_scan_pkg.sv
package rgb_scan_pkg;

    typedef enum logic {
        MODE_SYNC = 1'b0,
        MODE_DE   = 1'b1
    } panel_mode_e;

    typedef struct packed {
        logic de;
        logic hsync_n;
        logic vsync_n;
    } scan_flags_t;

    localparam int unsigned PIX_W = 24;

    function automatic logic in_bounds(input int unsigned val,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (val >= lo) && (val <= hi);
    endfunction

endpackage

// File: rtl/scan_total_reg.sv
module scan_total_reg #(
    parameter int unsigned W   = 11,
    parameter int unsigned MIN = 1324,
    parameter int unsigned MAX = 1364,
    parameter int unsigned DEF = 1344
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] val,
    input  logic         load,
    output logic [W-1:0] act
);
    import rgb_scan_pkg::*;

    localparam logic [W-1:0] DEF_W = W'(DEF);

    logic [W-1:0] pend;
    logic         ok;

    assign ok = in_bounds(int'(val), MIN, MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= DEF_W;
            act  <= DEF_W;
        end else begin
            if (we && ok)
                pend <= val;
            if (load)
                act <= pend;
        end
    end

    // R7 (line total instance) / R8 (frame total instance)
    assert_reject_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (we && !ok) |=> $stable(pend));
    assert_act_frame_only_R7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(act));
    // R8: the active total never leaves its legal range
    assert_act_legal_R8: assert property (@(posedge clk) disable iff (rst)
        (int'(act) >= MIN) && (int'(act) <= MAX));

endmodule

// File: rtl/scan_counters.sv
module scan_counters #(
    parameter int unsigned HW = 11,
    parameter int unsigned VW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] htot,
    input  logic [VW-1:0] vtot,
    output logic          run,
    output logic [HW-1:0] h,
    output logic [VW-1:0] v,
    output logic [HW-1:0] h_nxt,
    output logic [VW-1:0] v_nxt,
    output logic          wrap
);
    logic h_end, v_end;

    assign h_end = (h == htot - HW'(1));
    assign v_end = (v == vtot - VW'(1));
    assign wrap  = run && h_end && v_end;

    always_comb begin
        h_nxt = h;
        v_nxt = v;
        if (!run) begin
            h_nxt = '0;
            v_nxt = '0;
        end else if (h_end) begin
            h_nxt = '0;
            v_nxt = v_end ? '0 : v + VW'(1);
        end else begin
            h_nxt = h + HW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            h   <= '0;
            v   <= '0;
        end else begin
            run <= 1'b1;
            h   <= h_nxt;
            v   <= v_nxt;
        end
    end

    assert_h_bound_R2: assert property (@(posedge clk) disable iff (rst)
        h < htot);
    assert_v_bound_R2: assert property (@(posedge clk) disable iff (rst)
        v < vtot);
    assert_prime_R1: assert property (@(posedge clk) disable iff (rst)
        !run |=> (h == '0) && (v == '0));

endmodule

// File: rtl/scan_decode.sv
module scan_decode #(
    parameter int unsigned HW      = 11,
    parameter int unsigned VW      = 10,
    parameter int unsigned H_ACT   = 1024,
    parameter int unsigned V_ACT   = 600,
    parameter int unsigned HSYNC_W = 20,
    parameter int unsigned VSYNC_W = 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           run,
    input  logic [HW-1:0]                  h,
    input  logic [VW-1:0]                  v,
    input  logic [HW-1:0]                  h_nxt,
    input  logic [VW-1:0]                  v_nxt,
    input  logic [rgb_scan_pkg::PIX_W-1:0] pix_in,
    output rgb_scan_pkg::scan_flags_t      flags,
    output logic                           pix_req,
    output logic [rgb_scan_pkg::PIX_W-1:0] pix_out
);
    import rgb_scan_pkg::*;

    localparam logic [HW-1:0] HA  = HW'(H_ACT);
    localparam logic [VW-1:0] VA  = VW'(V_ACT);
    localparam logic [HW-1:0] HSE = HW'(H_ACT + HSYNC_W);
    localparam logic [VW-1:0] VSE = VW'(V_ACT + VSYNC_W);

    logic live;

    assign live = run && !rst;

    always_comb begin
        flags.de      = live && (h < HA) && (v < VA);
        flags.hsync_n = !(live && (h >= HA) && (h < HSE));
        flags.vsync_n = !(live && (v >= VA) && (v < VSE));
        pix_req       = !rst && (h_nxt < HA) && (v_nxt < VA);
        pix_out       = flags.de ? pix_in : '0;
    end

    assert_req_leads_de_R5: assert property (@(posedge clk) disable iff (rst)
        pix_req |=> flags.de);
    assert_sync_in_blank_R4: assert property (@(posedge clk) disable iff (rst)
        flags.de |-> (flags.hsync_n && flags.vsync_n));
    assert_de_follows_req_R5: assert property (@(posedge clk) disable iff (rst)
        (flags.de && run) |-> $past(pix_req));

endmodule

// File: rtl/rgb_scan_gen.sv
module rgb_scan_gen #(
    parameter int unsigned H_ACT     = 1024,
    parameter int unsigned H_TOT_MIN = 1324,
    parameter int unsigned H_TOT_MAX = 1364,
    parameter int unsigned H_TOT_DEF = 1344,
    parameter int unsigned V_ACT     = 600,
    parameter int unsigned V_TOT_MIN = 625,
    parameter int unsigned V_TOT_MAX = 645,
    parameter int unsigned V_TOT_DEF = 635,
    parameter int unsigned HSYNC_W   = 20,
    parameter int unsigned VSYNC_W   = 3,
    localparam int unsigned HW = $clog2(H_TOT_MAX + 1),
    localparam int unsigned VW = $clog2(V_TOT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [HW-1:0] cfg_htotal,
    input  logic [VW-1:0] cfg_vtotal,
    input  logic          mode_req,
    input  logic [23:0]   pix_in,
    output logic          pix_req,
    output logic [23:0]   pix_out,
    output logic          de,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          panel_mode,
    output logic [HW-1:0] h_cnt,
    output logic [VW-1:0] v_cnt
);
    import rgb_scan_pkg::*;

    logic [HW-1:0] htot, h_nxt;
    logic [VW-1:0] vtot, v_nxt;
    logic          run, wrap;
    scan_flags_t   flags;
    panel_mode_e   mode_q;

    scan_total_reg #(.W(HW), .MIN(H_TOT_MIN), .MAX(H_TOT_MAX), .DEF(H_TOT_DEF)) u_htot (
        .clk(clk), .rst(rst), .we(cfg_we), .val(cfg_htotal), .load(wrap), .act(htot)
    );

    scan_total_reg #(.W(VW), .MIN(V_TOT_MIN), .MAX(V_TOT_MAX), .DEF(V_TOT_DEF)) u_vtot (
        .clk(clk), .rst(rst), .we(cfg_we), .val(cfg_vtotal), .load(wrap), .act(vtot)
    );

    scan_counters #(.HW(HW), .VW(VW)) u_cnt (
        .clk(clk), .rst(rst), .htot(htot), .vtot(vtot), .run(run),
        .h(h_cnt), .v(v_cnt), .h_nxt(h_nxt), .v_nxt(v_nxt), .wrap(wrap)
    );

    scan_decode #(.HW(HW), .VW(VW), .H_ACT(H_ACT), .V_ACT(V_ACT),
                  .HSYNC_W(HSYNC_W), .VSYNC_W(VSYNC_W)) u_dec (
        .clk(clk), .rst(rst), .run(run), .h(h_cnt), .v(v_cnt),
        .h_nxt(h_nxt), .v_nxt(v_nxt), .pix_in(pix_in),
        .flags(flags), .pix_req(pix_req), .pix_out(pix_out)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_DE;
        else if (wrap)
            mode_q <= panel_mode_e'(mode_req);
    end

    assign de         = flags.de;
    assign hsync_n    = flags.hsync_n;
    assign vsync_n    = flags.vsync_n;
    assign panel_mode = mode_q;

    assert_mode_frame_only_R9: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(panel_mode));

endmodule

// File: tb/sim_rgb_scan_gen.sv
module sim_rgb_scan_gen;
    localparam int HA = 16, HMIN = 24, HMAX = 28, HDEF = 26, HSW = 3;
    localparam int VA = 6,  VMIN = 9,  VMAX = 11, VDEF = 10, VSW = 2;
    localparam int HW = $clog2(HMAX + 1);
    localparam int VW = $clog2(VMAX + 1);

    logic clk = 0;
    logic rst = 1;
    logic cfg_we = 0;
    logic [HW-1:0] cfg_htotal = '0;
    logic [VW-1:0] cfg_vtotal = '0;
    logic mode_req = 1;
    logic [23:0] pix_in = '0;
    logic pix_req, de, hsync_n, vsync_n, panel_mode;
    logic [23:0] pix_out;
    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;

    int total = 0, bad = 0, cycles = 0;
    bit done = 0;

    rgb_scan_gen #(.H_ACT(HA), .H_TOT_MIN(HMIN), .H_TOT_MAX(HMAX), .H_TOT_DEF(HDEF),
                   .V_ACT(VA), .V_TOT_MIN(VMIN), .V_TOT_MAX(VMAX), .V_TOT_DEF(VDEF),
                   .HSYNC_W(HSW), .VSYNC_W(VSW)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_htotal(cfg_htotal),
        .cfg_vtotal(cfg_vtotal), .mode_req(mode_req), .pix_in(pix_in),
        .pix_req(pix_req), .pix_out(pix_out), .de(de), .hsync_n(hsync_n),
        .vsync_n(vsync_n), .panel_mode(panel_mode), .h_cnt(h_cnt), .v_cnt(v_cnt)
    );

    always #4 clk = ~clk;

    // reference model state
    int m_h = 0, m_v = 0, m_ha = HDEF, m_va = VDEF, m_ph = HDEF, m_pv = VDEF;
    bit m_run = 0, m_mode = 1;

    function automatic bit act(int x, int y);
        return (x < HA) && (y < VA);
    endfunction

    function automatic int nxt_h(int h, int ha, bit run);
        if (!run) return 0;
        return (h == ha - 1) ? 0 : h + 1;
    endfunction

    function automatic int nxt_v(int h, int v, int ha, int va, bit run);
        if (!run) return 0;
        if (h != ha - 1) return v;
        return (v == va - 1) ? 0 : v + 1;
    endfunction

    always @(posedge clk) begin
        pix_in <= 24'($urandom);
        cycles <= cycles + 1;
        if (rst) begin
            m_h = 0; m_v = 0; m_run = 0; m_mode = 1;
            m_ha = HDEF; m_va = VDEF; m_ph = HDEF; m_pv = VDEF;
        end else begin
            bit wrap;
            int nh, nv;
            wrap = m_run && (m_h == m_ha - 1) && (m_v == m_va - 1);
            nh = nxt_h(m_h, m_ha, m_run);
            nv = nxt_v(m_h, m_v, m_ha, m_va, m_run);
            if (wrap) begin
                m_ha = m_ph; m_va = m_pv; m_mode = mode_req;
            end
            if (cfg_we) begin
                if (int'(cfg_htotal) >= HMIN && int'(cfg_htotal) <= HMAX) m_ph = cfg_htotal;
                if (int'(cfg_vtotal) >= VMIN && int'(cfg_vtotal) <= VMAX) m_pv = cfg_vtotal;
            end
            m_h = nh; m_v = nv; m_run = 1;
        end
    end

    task automatic chk(string req, logic [31:0] a, logic [31:0] e);
        total++;
        if (a !== e) begin
            bad++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, a, e);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (!done) begin
            bit e_de, e_hs, e_vs, e_req;
            bit live;
            live = m_run && !rst;
            e_de = live && act(m_h, m_v);
            e_hs = !(live && m_h >= HA && m_h < HA + HSW);
            e_vs = !(live && m_v >= VA && m_v < VA + VSW);
            e_req = !rst && act(nxt_h(m_h, m_ha, m_run), nxt_v(m_h, m_v, m_ha, m_va, m_run));
            chk("R2 h_cnt (R1 R7 when reset/total)", 32'(h_cnt), 32'(m_h));
            chk("R2 v_cnt (R8 R10 frame total)", 32'(v_cnt), 32'(m_v));
            chk(rst ? "R1 de idle" : "R3 de", 32'(de), 32'(e_de));
            chk("R4 hsync_n", 32'(hsync_n), 32'(e_hs));
            chk("R4 vsync_n", 32'(vsync_n), 32'(e_vs));
            chk("R5 pix_req", 32'(pix_req), 32'(e_req));
            chk("R6 pix_out", 32'(pix_out), e_de ? 32'(pix_in) : 32'd0);
            chk("R9 panel_mode", 32'(panel_mode), 32'(m_mode));
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_cfg(int hv, int vv);
        @(negedge clk);
        cfg_htotal = HW'(hv);
        cfg_vtotal = VW'(vv);
        cfg_we = 1;
        @(negedge clk);
        cfg_we = 0;
    endtask

    initial begin
        void'($urandom(32'h5eed));
        wait_cyc(5);
        rst = 0;
        wait_cyc(2 * HDEF * VDEF);           // R10 defaults, R1 priming
        write_cfg(HMAX, VMIN);              // R7/R8 legal end values
        wait_cyc(3 * HMAX * VMAX);
        write_cfg(HMIN - 1, VMAX + 1);      // both rejected
        wait_cyc(2 * HMAX * VMAX);
        write_cfg(HMIN, VMAX + 2);          // R7 accepted, R8 rejected
        wait_cyc(2 * HMAX * VMAX);
        write_cfg(HMAX + 1, VMAX);          // R7 rejected, R8 accepted
        mode_req = 0;                       // R9
        wait_cyc(2 * HMAX * VMAX);
        mode_req = 1;
        wait_cyc(HMAX * VMAX + 7);
        rst = 1; wait_cyc(2); rst = 0;      // reset mid-frame, R1
        for (int k = 0; k < 60; k++) begin
            wait_cyc($urandom_range(400));
            mode_req = 1'($urandom);
            write_cfg(int'($urandom_range(31, 20)), int'($urandom_range(15, 6)));
            if ($urandom_range(19) == 0) begin
                rst = 1; wait_cyc(1 + $urandom_range(2)); rst = 0;
            end
        end
        wait_cyc(2 * HMAX * VMAX);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        if (cycles > 190000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule